// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Receiver

This block turns an asynchronous serial line into words for a processor bus. It samples the line on every pulse of a receive-time enable that runs at sixteen times the bit rate. It finds the start bit, takes each data bit by a three-sample vote near mid-bit, and assembles the frame in a hidden shift register. Once the stop bit is resolved, the word moves into a data register that the bus can see. The flag for "word ready" is raised at that same moment.

Because the receiver is double-buffered, a second frame can shift in while the first still waits in the data register. If the first word is still unread when the second frame ends, the second frame is dropped and an overrun flag is raised. Noise, parity and framing errors are collected while bits arrive. They become visible only when a word actually lands in the data register. The flags clear through a two-step bus sequence: a status read, then a data read. An idle-line indicator and a ready interrupt complete the block.

Top module: `sci_rx_core`

## Requirements
- R1: While `rx_en` is 0 the receiver accepts no frame and `line_idle` is 0. Frames sent in that time leave `rdy` and `rx_data` unchanged.
- R2: A falling line starts a candidate start bit; that tick is sample 0. The start bit is confirmed only if the majority of samples 7, 8 and 9 is 0. Otherwise the receiver returns to waiting and no word or flag results.
- R3: Each data bit is the majority of its samples 7, 8 and 9, and data bits arrive LSB first. With `long_mode`=0 a frame has 8 data bits and `rx_data[8]` reads 0. With `long_mode`=1 it has 9 data bits.
- R4: When the stop bit is resolved and `rdy` is 0, the assembled word appears on `rx_data` and `rdy` rises in the same cycle.
- R5: `noise_err` is set with the word if the three samples of any bit in the frame (start, data or stop) disagree. Disagreement outside samples 7 to 9 is ignored.
- R6: With `par_en`=1 the last data bit is a parity bit and stays in `rx_data`. `parity_err` is set when the count of ones over all data bits is odd with `par_odd`=0, or even with `par_odd`=1. With `par_en`=0, `parity_err` stays 0.
- R7: A stop bit whose majority is 0 sets `frame_err` along with the word.
- R8: If `rdy` is still 1 when a frame ends, `ovr` is set. `rx_data`, `noise_err`, `parity_err` and `frame_err` keep their values, and the new frame is lost. `ovr` is never 1 while `rdy` is 0.
- R9: A `rd_stat` pulse followed by a `rd_data` pulse, with neither an `acc_other` pulse nor a frame end between them, clears `rdy`, `ovr`, `noise_err`, `parity_err` and `frame_err`.
- R10: An `acc_other` pulse, or a frame end, between the status read and the data read cancels the clear. A `rd_data` with no prior `rd_stat` also clears nothing.
- R11: `irq` is 1 exactly when `irq_en` is 1 and `rdy` is 1.
- R12: `line_idle` rises after the line has been 1 for 16 times the frame length in ticks (10 bits with `long_mode`=0, 11 with `long_mode`=1) while waiting for a start bit. It drops on the next 0 sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rt_tick | input | 1 | Receive-time enable, one pulse per sample (16 per bit) |
| rx_in | input | 1 | Asynchronous serial line, idle high |
| rx_en | input | 1 | Receiver enable |
| long_mode | input | 1 | 0: 8 data bits, 1: 9 data bits |
| par_en | input | 1 | Last data bit is parity |
| par_odd | input | 1 | Parity sense: 0 even, 1 odd |
| irq_en | input | 1 | Ready interrupt enable |
| rd_stat | input | 1 | One-cycle pulse: status register read |
| rd_data | input | 1 | One-cycle pulse: data register read |
| acc_other | input | 1 | One-cycle pulse: any other register access |
| rx_data | output | 9 | Receive data register |
| rdy | output | 1 | Word ready |
| ovr | output | 1 | Overrun |
| noise_err | output | 1 | Noise seen in the word |
| parity_err | output | 1 | Parity mismatch in the word |
| frame_err | output | 1 | Stop bit sampled as 0 |
| line_idle | output | 1 | Idle line detected |
| irq | output | 1 | Interrupt request |

## Verification
The properties assume that `long_mode`, `par_en` and `par_odd` stay fixed while a frame is in flight. They also assume that the three bus strobes are single-cycle and never high together. The stimulus only changes configuration between frames, with the line idle. It issues each strobe as an isolated one-cycle pulse between negative clock edges. Line changes are made just after a sampling tick, so each intended sample value is seen by exactly one tick through the input synchronizer.

// File: rtl/sci_rx_pkg.sv
package sci_rx_pkg;
  localparam int unsigned DATA_W = 9;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_st_e;

  typedef struct packed {
    logic [DATA_W-1:0] data;
    logic              noise;
    logic              perr;
    logic              ferr;
  } rx_word_t;

  // two-of-three vote
  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  // any sample in a group that differs from the others
  function automatic logic split3(input logic a, input logic b, input logic c);
    return (a ^ b) | (b ^ c);
  endfunction

  // number of data bits in a frame
  function automatic logic [3:0] data_bits(input logic long_m);
    return long_m ? 4'd9 : 4'd8;
  endfunction

  // mismatch between the ones count over the data bits and the parity sense
  function automatic logic parity_bad(input logic [DATA_W-1:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction
endpackage

// File: rtl/rx_bit_sampler.sv
module rx_bit_sampler
  import sci_rx_pkg::*;
#(
  parameter int unsigned OSR = 16
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     rt_tick,
  input  logic     rx_s,
  input  logic     rx_en,
  input  logic     long_mode,
  input  logic     par_en,
  input  logic     par_odd,
  output logic     frame_done,
  output rx_word_t word,
  output logic     line_idle
);
  localparam int unsigned PW  = $clog2(OSR);
  localparam int unsigned MID = OSR / 2;
  localparam logic [PW-1:0] P_A = PW'(MID - 1);
  localparam logic [PW-1:0] P_B = PW'(MID);
  localparam logic [PW-1:0] P_C = PW'(MID + 1);
  localparam int unsigned IDLE_MAX = OSR * 11;
  localparam int unsigned IW = $clog2(IDLE_MAX + 1);
  localparam logic [IW-1:0] IDLE_SHORT = IW'(OSR * 10);
  localparam logic [IW-1:0] IDLE_LONG  = IW'(IDLE_MAX);

  rx_st_e            st;
  logic [PW-1:0]     phase;
  logic [3:0]        bit_idx;
  logic              s_a, s_b;
  logic [DATA_W-1:0] shreg;
  logic              noise_acc;
  logic [IW-1:0]     hi_cnt;

  // named events for checking
  logic vote, vote_split, at_vote, last_bit;
  assign at_vote    = rt_tick && (st != RX_IDLE) && (phase == P_C);
  assign vote       = maj3(s_a, s_b, rx_s);
  assign vote_split = split3(s_a, s_b, rx_s);
  assign last_bit   = (bit_idx == data_bits(long_mode) - 4'd1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= RX_IDLE;
      phase <= '0;
      bit_idx <= '0;
      s_a <= 1'b1;
      s_b <= 1'b1;
      shreg <= '0;
      noise_acc <= 1'b0;
      frame_done <= 1'b0;
      word <= '0;
    end else begin
      frame_done <= 1'b0;
      if (!rx_en) begin
        st <= RX_IDLE;
      end else if (rt_tick) begin
        if (st == RX_IDLE) begin
          if (!rx_s) begin
            st <= RX_START;
            phase <= PW'(1);
            shreg <= '0;
            noise_acc <= 1'b0;
          end
        end else begin
          phase <= phase + PW'(1);
          if (phase == P_A) s_a <= rx_s;
          if (phase == P_B) s_b <= rx_s;
          if (phase == P_C) begin
            unique case (st)
              RX_START: begin
                if (vote) st <= RX_IDLE;
                else begin
                  st <= RX_DATA;
                  bit_idx <= '0;
                  noise_acc <= vote_split;
                end
              end
              RX_DATA: begin
                shreg <= shreg | (DATA_W'(vote) << bit_idx);
                noise_acc <= noise_acc | vote_split;
                if (last_bit) st <= RX_STOP;
                else bit_idx <= bit_idx + 4'd1;
              end
              RX_STOP: begin
                st <= RX_IDLE;
                frame_done <= 1'b1;
                word.data <= shreg;
                word.noise <= noise_acc | vote_split;
                word.perr <= par_en & parity_bad(shreg, par_odd);
                word.ferr <= ~vote;
              end
              default: st <= RX_IDLE;
            endcase
          end
        end
      end
    end
  end

  // idle-line run counter, counts high samples while waiting
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hi_cnt <= '0;
    else if (!rx_en || st != RX_IDLE) hi_cnt <= '0;
    else if (rt_tick) begin
      if (!rx_s) hi_cnt <= '0;
      else if (hi_cnt != IDLE_LONG) hi_cnt <= hi_cnt + IW'(1);
    end
  end

  assign line_idle = rx_en && (hi_cnt >= (long_mode ? IDLE_LONG : IDLE_SHORT));

  // R1
  off_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (st == RX_IDLE) && !line_idle);
  // R3
  bit_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == RX_DATA) |-> (bit_idx < data_bits(long_mode)));
  // R4
  done_from_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> ($past(st) == RX_STOP));
  // R12
  idle_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_idle |-> (st == RX_IDLE));
endmodule

// File: rtl/rx_flag_regs.sv
module rx_flag_regs
  import sci_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_done,
  input  rx_word_t          word,
  input  logic              rd_stat,
  input  logic              rd_data,
  input  logic              acc_other,
  output logic [DATA_W-1:0] data_q,
  output logic              rdy,
  output logic              ovr,
  output logic              nf,
  output logic              pf,
  output logic              fe
);
  logic armed;
  logic clear_fire;
  logic overrun_ev;

  assign overrun_ev = frame_done && rdy;
  assign clear_fire = armed && rd_data && !frame_done && !acc_other;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else if (frame_done || acc_other) armed <= 1'b0;
    else if (rd_stat) armed <= 1'b1;
    else if (rd_data) armed <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      rdy <= 1'b0;
      ovr <= 1'b0;
      nf <= 1'b0;
      pf <= 1'b0;
      fe <= 1'b0;
    end else if (frame_done) begin
      if (rdy) ovr <= 1'b1;
      else begin
        data_q <= word.data;
        rdy <= 1'b1;
        nf <= word.noise;
        pf <= word.perr;
        fe <= word.ferr;
      end
    end else if (clear_fire) begin
      rdy <= 1'b0;
      ovr <= 1'b0;
      nf <= 1'b0;
      pf <= 1'b0;
      fe <= 1'b0;
    end
  end

  // R4
  rdy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy) |-> $past(frame_done));
  // R8
  ovr_needs_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr |-> rdy);
  // R8
  ovr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_ev |=> $stable(data_q) && ovr && $stable({nf, pf, fe}));
  // R9
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && rd_data && !frame_done && !acc_other) |=> !rdy && !ovr && !nf && !pf && !fe);
  // R10
  no_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data && !armed && !frame_done) |=> $stable(rdy) && $stable(ovr));
endmodule

// File: rtl/sci_rx_core.sv
module sci_rx_core
  import sci_rx_pkg::*;
#(
  parameter int unsigned OSR         = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rt_tick,
  input  logic              rx_in,
  input  logic              rx_en,
  input  logic              long_mode,
  input  logic              par_en,
  input  logic              par_odd,
  input  logic              irq_en,
  input  logic              rd_stat,
  input  logic              rd_data,
  input  logic              acc_other,
  output logic [DATA_W-1:0] rx_data,
  output logic              rdy,
  output logic              ovr,
  output logic              noise_err,
  output logic              parity_err,
  output logic              frame_err,
  output logic              line_idle,
  output logic              irq
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   rx_s;
  logic                   frame_done;
  rx_word_t               word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else sync_q <= {sync_q[SYNC_STAGES-2:0], rx_in};
  end
  assign rx_s = sync_q[SYNC_STAGES-1];

  rx_bit_sampler #(.OSR(OSR)) u_samp (
    .clk(clk), .rst_n(rst_n), .rt_tick(rt_tick), .rx_s(rx_s), .rx_en(rx_en),
    .long_mode(long_mode), .par_en(par_en), .par_odd(par_odd),
    .frame_done(frame_done), .word(word), .line_idle(line_idle)
  );

  rx_flag_regs u_flags (
    .clk(clk), .rst_n(rst_n), .frame_done(frame_done), .word(word),
    .rd_stat(rd_stat), .rd_data(rd_data), .acc_other(acc_other),
    .data_q(rx_data), .rdy(rdy), .ovr(ovr), .nf(noise_err), .pf(parity_err), .fe(frame_err)
  );

  assign irq = irq_en & rdy;

  // R11
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> irq_en && ($rose(rdy) || $rose(irq_en)));
endmodule

// File: tb/sim_sci_rx_core.sv
module sim_sci_rx_core;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rt_tick = 1'b0;
  logic rx_in = 1'b1;
  logic rx_en = 1'b0, long_mode = 1'b0, par_en = 1'b0, par_odd = 1'b0, irq_en = 1'b0;
  logic rd_stat = 1'b0, rd_data = 1'b0, acc_other = 1'b0;
  logic [8:0] rx_data;
  logic rdy, ovr, noise_err, parity_err, frame_err, line_idle, irq;
  int checks = 0, failures = 0;
  int tickc = 0;
  bit done = 1'b0;

  sci_rx_core u0 (.*);

  always #10 clk = ~clk;

  always @(negedge clk) begin
    tickc = (tickc + 1) % 4;
    rt_tick = (tickc == 0);
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick_wait();
    @(posedge clk iff rt_tick);
    @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) tick_wait();
  endtask

  // one frame, one line value per sample; gb/gs flip one sample
  task automatic send_frame(input logic [8:0] d, input logic lm, input logic stop_v,
                            input int gb, input int gs);
    int nb;
    logic v;
    nb = lm ? 9 : 8;
    for (int b = 0; b < nb + 2; b++) begin
      for (int j = 0; j < 16; j++) begin
        if (b == 0) v = 1'b0;
        else if (b <= nb) v = d[b-1];
        else v = (j >= 10) ? 1'b1 : stop_v;
        if (b == gb && j == gs) v = ~v;
        rx_in = v;
        tick_wait();
      end
    end
    rx_in = 1'b1;
  endtask

  task automatic pulse(input int which);
    if (which == 0) rd_stat = 1'b1;
    else if (which == 1) rd_data = 1'b1;
    else acc_other = 1'b1;
    @(negedge clk);
    rd_stat = 1'b0; rd_data = 1'b0; acc_other = 1'b0;
    @(negedge clk);
  endtask

  task automatic flags(input string req, input logic [4:0] exp);
    check(req, {rdy, ovr, noise_err, parity_err, frame_err}, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [8:0] w;
    logic [8:0] prev;
    logic bad;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    flags("R4 reset", 5'b0);
    check("R11 reset irq", irq, 0);
    check("R1 reset idle", line_idle, 0);

    // R1: disabled, frames ignored, idle held low
    ticks(200);
    check("R1 idle off", line_idle, 0);
    send_frame(9'h044, 1'b0, 1'b1, -1, 0);
    flags("R1 disabled frame", 5'b0);
    check("R1 data untouched", rx_data, 0);

    // R12: idle after 160 / 176 high ticks
    rx_en = 1'b1;
    ticks(150);
    check("R12 short early", line_idle, 0);
    ticks(12);
    check("R12 short reached", line_idle, 1);
    long_mode = 1'b1;
    @(negedge clk);
    check("R12 long not yet", line_idle, 0);
    ticks(16);
    check("R12 long reached", line_idle, 1);
    long_mode = 1'b0;

    // R2: false start
    for (int j = 0; j < 6; j++) begin rx_in = 1'b0; tick_wait(); end
    rx_in = 1'b1;
    check("R12 drops on low", line_idle, 0);
    ticks(30);
    flags("R2 false start", 5'b0);

    // sweep over frame length, parity, values
    for (int cfg = 0; cfg < 4; cfg++) begin
      long_mode = cfg[0];
      par_en = cfg[1];
      for (int i = 0; i < 16; i++) begin
        int nb;
        nb = long_mode ? 9 : 8;
        par_odd = i[0];
        irq_en = i[1];
        w = 9'((i * 53 + cfg * 7 + 3) % 512) & ((long_mode) ? 9'h1FF : 9'h0FF);
        bad = 1'b0;
        if (par_en) begin
          int ones;
          ones = 0;
          for (int k = 0; k < nb - 1; k++) ones += int'(w[k]);
          w[nb-1] = ((ones % 2) == 1) ^ par_odd;
          if (i % 5 == 2) begin w[nb-1] = ~w[nb-1]; bad = 1'b1; end
        end
        send_frame(w, long_mode, 1'b1, -1, 0);
        check("R3 data", rx_data, w);
        flags(bad ? "R6 parity bad" : "R4 R6 flags", {1'b1, 1'b0, 1'b0, bad, 1'b0});
        check("R11 irq", irq, irq_en);
        pulse(0); pulse(1);
        flags("R9 cleared", 5'b0);
        check("R11 irq low", irq, 0);
      end
    end
    par_en = 1'b0; long_mode = 1'b0; irq_en = 1'b0;

    // R5: noise inside window, outside window, on stop bit
    send_frame(9'h0A5, 1'b0, 1'b1, 4, 8);
    check("R5 data by vote", rx_data, 9'h0A5);
    flags("R5 noise set", 5'b10100);
    pulse(0); pulse(1);
    send_frame(9'h0A5, 1'b0, 1'b1, 4, 3);
    flags("R5 outside window", 5'b10000);
    pulse(0); pulse(1);
    send_frame(9'h03C, 1'b0, 1'b1, 9, 7);
    flags("R5 stop noise", 5'b10100);
    pulse(0); pulse(1);

    // R7: framing
    send_frame(9'h0C3, 1'b0, 1'b0, -1, 0);
    check("R7 data", rx_data, 9'h0C3);
    flags("R7 framing", 5'b10001);
    pulse(0); pulse(1);

    // R8: overrun keeps old data, new frame's error not shown
    send_frame(9'h03C, 1'b0, 1'b1, -1, 0);
    prev = rx_data;
    send_frame(9'h081, 1'b0, 1'b0, 3, 8);
    check("R8 data kept", rx_data, prev);
    flags("R8 overrun only", 5'b11000);
    pulse(0); pulse(1);
    flags("R9 clear after overrun", 5'b0);

    // R10: other access cancels, lone data read does nothing
    send_frame(9'h011, 1'b0, 1'b1, -1, 0);
    pulse(1);
    flags("R10 data read alone", 5'b10000);
    pulse(0); pulse(2); pulse(1);
    flags("R10 other access cancels", 5'b10000);
    pulse(0); pulse(1);
    flags("R9 proper sequence", 5'b0);

    // R10: frame end between reads cancels
    send_frame(9'h022, 1'b0, 1'b1, -1, 0);
    pulse(0);
    send_frame(9'h033, 1'b0, 1'b1, -1, 0);
    pulse(1);
    flags("R10 event cancels", 5'b11000);
    check("R8 data kept 2", rx_data, 9'h022);
    pulse(0); pulse(1);
    flags("R9 final clear", 5'b0);

    // R2: receiver back to normal after false start; R11 irq enable
    irq_en = 1'b1;
    send_frame(9'h05A, 1'b0, 1'b1, -1, 0);
    check("R2 frame after", rx_data, 9'h05A);
    check("R11 irq on", irq, 1);
    check("R12 not idle after frame", line_idle, 0);
    irq_en = 1'b0;
    @(negedge clk);
    check("R11 irq masked", irq, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule